// File: doc/BRIEF.md
# Converter Serial Readout Master

This block sits on the digital side of a sampling converter and streams every 16-bit result to a host over a three-wire serial link that it drives itself. The block generates the serial clock and a framing strobe. The host only listens. A conversion-start request opens a conversion, which is modelled as a busy period of fixed length. The sample word presented on `sample_in` is captured at the moment busy drops.

The `read_prev` input picks when a word leaves the block. When it is low, the fresh result is shifted out as soon as the conversion ends. When it is high, the result of the previous conversion is shifted out while the next conversion runs. Two inputs flip the polarity of the serial clock and of the frame strobe. The link is driven only while `serial_en` is high and `clk_ext_sel` is low. In every other case the link stays at its idle levels.

Top module: `adc_serial_master`

## Requirements
- R1: During and after reset, `busy` is 0, `frame` is at its inactive level, `sclk` is at its idle level and `sdata` is 0.
- R2: `busy` rises in the cycle after `conv_start` is sampled high while idle, and it stays high for exactly CONV_CYCLES cycles (default 72).
- R3: A `conv_start` that arrives while `busy` is high is ignored. This includes the last busy cycle. The busy period is not stretched, and no new busy period follows.
- R4: Each frame carries exactly 16 clock pulses and sends the word most significant bit first. The frame strobe is active for the whole transfer. The logical clock idles low and each pulse is high-going before any inversion.
- R5: With `read_prev` = 0, the word sent is the one captured at the end of that conversion. The frame becomes active in the same cycle in which `busy` falls.
- R6: With `read_prev` = 1, the word sent is the one captured by the previous conversion. The frame becomes active in the same cycle in which `busy` rises and ends while `busy` is still high. The first such frame after reset carries 0x0000.
- R7: `sdata` changes only while the logical clock is low and was low in the cycle before. It is therefore stable across both the rising and the falling clock edge.
- R8: `inv_sclk` = 1 makes `sclk` idle high with low-going pulses. `inv_frame` = 1 makes `frame` active low. The data content does not change.
- R9: While `serial_en` = 0 or `clk_ext_sel` = 1, no frame is started, `sclk` stays idle and `sdata` stays 0. Conversions and `busy` timing are unaffected.
- R10: One bit lasts DIV system clocks (default 4). The frame strobe is active for exactly 16×DIV cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_start | input | 1 | Request to start a conversion |
| serial_en | input | 1 | High enables the serial link |
| clk_ext_sel | input | 1 | Low selects the internally generated clock (master operation) |
| read_prev | input | 1 | 0: send the new result after conversion; 1: send the previous result during conversion |
| inv_sclk | input | 1 | Inverts the serial clock polarity |
| inv_frame | input | 1 | Inverts the frame strobe polarity |
| sample_in | input | 16 | Conversion result, captured when busy falls |
| busy | output | 1 | High while a conversion is in progress |
| sclk | output | 1 | Generated serial clock |
| frame | output | 1 | Frame strobe, active while the data are valid |
| sdata | output | 1 | Serial data, MSB first |

## Verification
Two events can fall in the same cycle. A new conversion request can arrive in the last busy cycle, which is exactly the cycle that ends the conversion and, in the after-conversion mode, launches the frame. The bench raises `conv_start` once in mid-conversion and once in that final busy cycle. It then judges that the busy period kept its exact length, that no second busy period follows, and that the frame still carries the correct word. In the during-conversion mode, the frame start and the busy rise share a cycle. The bench confirms that the frame carries the previous result, starts with busy already high and ends before busy falls.

// File: rtl/adc_serial_master.sv
module adc_serial_master #(
  parameter int WIDTH       = 16,
  parameter int DIV         = 4,
  parameter int CONV_CYCLES = 72
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_start,
  input  logic             serial_en,
  input  logic             clk_ext_sel,
  input  logic             read_prev,
  input  logic             inv_sclk,
  input  logic             inv_frame,
  input  logic [WIDTH-1:0] sample_in,
  output logic             busy,
  output logic             sclk,
  output logic             frame,
  output logic             sdata
);
  // DIV must be a multiple of 4; CONV_CYCLES must be at least WIDTH*DIV
  localparam int PW     = $clog2(DIV);
  localparam int BW     = $clog2(WIDTH);
  localparam int CW     = $clog2(CONV_CYCLES);
  localparam int HI_BEG = DIV / 4;
  localparam int HI_END = HI_BEG + DIV / 2;

  logic             busy_q;
  logic [CW-1:0]    cnt;
  logic [WIDTH-1:0] result;
  logic [WIDTH-1:0] sh;
  logic             act;
  logic [PW-1:0]    ph;
  logic [BW-1:0]    bitn;

  wire ser_on    = serial_en & ~clk_ext_sel;
  wire start_ok  = conv_start & ~busy_q;
  wire conv_done = busy_q & (cnt == '0);
  wire go_now    = conv_done & ~read_prev;
  wire go_prev   = start_ok & read_prev;
  wire launch    = ser_on & ~act & (go_now | go_prev);
  wire last_ph   = (ph == PW'(DIV - 1));
  wire last_bit  = (bitn == BW'(WIDTH - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt    <= '0;
      result <= '0;
    end else if (start_ok) begin
      busy_q <= 1'b1;
      cnt    <= CW'(CONV_CYCLES - 1);
    end else if (busy_q) begin
      if (conv_done) begin
        busy_q <= 1'b0;
        result <= sample_in;
      end else begin
        cnt <= cnt - CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act  <= 1'b0;
      ph   <= '0;
      bitn <= '0;
      sh   <= '0;
    end else if (!ser_on) begin
      act <= 1'b0;
    end else if (launch) begin
      act  <= 1'b1;
      ph   <= '0;
      bitn <= '0;
      sh   <= go_now ? sample_in : result;
    end else if (act) begin
      ph <= last_ph ? '0 : ph + PW'(1);
      if (last_ph) begin
        if (last_bit) begin
          act <= 1'b0;
        end else begin
          bitn <= bitn + BW'(1);
          sh   <= sh << 1;
        end
      end
    end
  end

  wire clk_hi = act && (int'(ph) >= HI_BEG) && (int'(ph) < HI_END);

  assign busy  = busy_q;
  assign sclk  = clk_hi ^ inv_sclk;
  assign frame = act ^ inv_frame;
  assign sdata = act & sh[WIDTH-1];
endmodule

// File: rtl/adc_serial_master_chk.sv
module adc_serial_master_chk #(
  parameter int WIDTH       = 16,
  parameter int DIV         = 4,
  parameter int CONV_CYCLES = 72
) (
  input logic clk,
  input logic rst_n,
  input logic conv_start,
  input logic serial_en,
  input logic clk_ext_sel,
  input logic inv_sclk,
  input logic inv_frame,
  input logic busy,
  input logic sclk,
  input logic frame,
  input logic sdata
);
  wire sclk_l = sclk ^ inv_sclk;
  wire fr_l   = frame ^ inv_frame;
  wire ser_on = serial_en & ~clk_ext_sel;

  int   busy_len;
  int   edges;
  logic sclk_l_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_len <= 0;
      edges    <= 0;
      sclk_l_q <= 1'b0;
    end else begin
      busy_len <= busy ? busy_len + 1 : 0;
      sclk_l_q <= sclk_l;
      if (!fr_l)                    edges <= 0;
      else if (sclk_l && !sclk_l_q) edges <= edges + 1;
    end
  end

  assert_busy_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(conv_start));

  assert_busy_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> busy_len < CONV_CYCLES);

  assert_busy_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(busy_len) == CONV_CYCLES - 1);

  assert_pulse_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
    edges <= WIDTH);

  assert_pulse_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fr_l) && $past(ser_on) |-> $past(edges) == WIDTH);

  assert_data_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fr_l && $past(fr_l) && !$stable(sdata) |-> !sclk_l && !$past(sclk_l));

  assert_link_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_on |=> !fr_l && !sclk_l && !sdata);
endmodule

bind adc_serial_master adc_serial_master_chk #(
  .WIDTH(WIDTH), .DIV(DIV), .CONV_CYCLES(CONV_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .serial_en(serial_en),
  .clk_ext_sel(clk_ext_sel), .inv_sclk(inv_sclk), .inv_frame(inv_frame),
  .busy(busy), .sclk(sclk), .frame(frame), .sdata(sdata)
);

// File: tb/test_adc_serial_master.sv
module test_adc_serial_master;
  localparam int WIDTH = 16;
  localparam int DIV   = 4;
  localparam int CONV  = 72;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv_start = 1'b0, serial_en = 1'b1, clk_ext_sel = 1'b0, read_prev = 1'b0;
  logic inv_sclk = 1'b0, inv_frame = 1'b0;
  logic [WIDTH-1:0] sample_in = '0;
  logic busy, sclk, frame, sdata;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  adc_serial_master #(.WIDTH(WIDTH), .DIV(DIV), .CONV_CYCLES(CONV)) i_adc_serial_master (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .serial_en(serial_en),
    .clk_ext_sel(clk_ext_sel), .read_prev(read_prev), .inv_sclk(inv_sclk),
    .inv_frame(inv_frame), .sample_in(sample_in), .busy(busy), .sclk(sclk),
    .frame(frame), .sdata(sdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  int          busy_cnt;
  logic [15:0] got;
  int          pulses, fr_len;
  bit          stable_ok, busy_first, busy_last, cap_to;

  task automatic busy_mon(input bit poke);
    busy_cnt = 0;
    while (busy && busy_cnt < 500) begin
      busy_cnt++;
      conv_start = poke && (busy_cnt == 3 || busy_cnt == CONV);
      @(negedge clk);
    end
    conv_start = 1'b0;
  endtask

  task automatic capture();
    int  wait_n = 0;
    bit  prev = 1'b0;
    bit  lastbit = 1'b0;
    got = '0; pulses = 0; fr_len = 0; stable_ok = 1'b1; cap_to = 1'b0;
    while (!(frame ^ inv_frame) && wait_n < 300) begin
      wait_n++;
      @(negedge clk);
    end
    if (wait_n >= 300) begin
      cap_to = 1'b1;
      return;
    end
    busy_first = busy;
    while (frame ^ inv_frame) begin
      bit s = sclk ^ inv_sclk;
      fr_len++;
      busy_last = busy;
      if (s && !prev) begin
        got = {got[14:0], sdata};
        lastbit = sdata;
        pulses++;
      end else if (!s && prev) begin
        if (sdata !== lastbit) stable_ok = 1'b0;
      end
      prev = s;
      @(negedge clk);
    end
  endtask

  task automatic run_conv(input logic [15:0] word, input bit mode, input bit poke);
    sample_in = word;
    read_prev = mode;
    @(negedge clk);
    conv_start = 1'b1;
    @(negedge clk);
    conv_start = 1'b0;
    chk(busy === 1'b1, "R2 busy one cycle after start", busy, 1);
    fork
      busy_mon(poke);
      capture();
    join
    chk(busy_cnt == CONV, "R2 busy length", busy_cnt, CONV);
  endtask

  task automatic frame_checks(input logic [15:0] exp, input string tag);
    chk(!cap_to, {tag, " R4 frame seen"}, cap_to, 0);
    chk(got == exp, {tag, " R4 word MSB first"}, got, exp);
    chk(pulses == WIDTH, {tag, " R4 pulse count"}, pulses, WIDTH);
    chk(fr_len == WIDTH * DIV, {tag, " R10 frame length"}, fr_len, WIDTH * DIV);
    chk(stable_ok, {tag, " R7 data stable on both edges"}, stable_ok, 1);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R1 busy in reset", busy, 0);
    chk(frame === 1'b0, "R1 frame in reset", frame, 0);
    chk(sclk === 1'b0, "R1 sclk in reset", sclk, 0);
    chk(sdata === 1'b0, "R1 sdata in reset", sdata, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy === 1'b0 && frame === 1'b0, "R1 idle after reset", {busy, frame}, 0);
  endtask

  task automatic t_mode_prev();
    run_conv(16'hA5C3, 1'b1, 1'b0);
    frame_checks(16'h0000, "first prev frame R6");
    chk(busy_first == 1'b1, "R6 frame starts with busy high", busy_first, 1);
    chk(busy_last == 1'b1, "R6 frame ends before busy falls", busy_last, 1);
    run_conv(16'h1234, 1'b1, 1'b0);
    frame_checks(16'hA5C3, "prev frame R6");
    chk(busy_first == 1'b1 && busy_last == 1'b1, "R6 frame within busy",
        {busy_first, busy_last}, 3);
  endtask

  task automatic t_mode_now();
    run_conv(16'h8001, 1'b0, 1'b0);
    frame_checks(16'h8001, "now frame R5");
    chk(busy_first == 1'b0, "R5 frame starts as busy falls", busy_first, 0);
    repeat (4) @(negedge clk);
    run_conv(16'h7FFE, 1'b0, 1'b0);
    frame_checks(16'h7FFE, "now frame R5");
    repeat (4) @(negedge clk);
    run_conv(16'h0F0F, 1'b1, 1'b0);
    frame_checks(16'h7FFE, "prev after now R6");
  endtask

  task automatic t_ignore();
    repeat (4) @(negedge clk);
    run_conv(16'hC0DE, 1'b0, 1'b1);
    frame_checks(16'hC0DE, "collision R3");
    begin
      bit rose = 1'b0;
      repeat (6) begin
        if (busy) rose = 1'b1;
        @(negedge clk);
      end
      chk(!rose, "R3 start during busy ignored", rose, 0);
    end
  endtask

  task automatic t_invert();
    inv_sclk = 1'b1;
    inv_frame = 1'b1;
    @(negedge clk);
    chk(sclk === 1'b1, "R8 inverted sclk idles high", sclk, 1);
    chk(frame === 1'b1, "R8 inverted frame inactive high", frame, 1);
    run_conv(16'h5A3C, 1'b0, 1'b0);
    frame_checks(16'h5A3C, "inverted R8");
    inv_sclk = 1'b0;
    inv_frame = 1'b0;
  endtask

  task automatic t_disabled(input bit use_ext);
    bit moved = 1'b0;
    if (use_ext) clk_ext_sel = 1'b1; else serial_en = 1'b0;
    sample_in = 16'hFFFF;
    read_prev = use_ext;
    @(negedge clk);
    conv_start = 1'b1;
    @(negedge clk);
    conv_start = 1'b0;
    busy_cnt = 0;
    while (busy && busy_cnt < 500) begin
      busy_cnt++;
      if (frame !== 1'b0 || sclk !== 1'b0 || sdata !== 1'b0) moved = 1'b1;
      @(negedge clk);
    end
    repeat (WIDTH * DIV + 8) begin
      if (frame !== 1'b0 || sclk !== 1'b0 || sdata !== 1'b0) moved = 1'b1;
      @(negedge clk);
    end
    chk(!moved, use_ext ? "R9 link idle with external clock select"
                        : "R9 link idle with serial disabled", moved, 0);
    chk(busy_cnt == CONV, "R9 busy unaffected", busy_cnt, CONV);
    serial_en = 1'b1;
    clk_ext_sel = 1'b0;
  endtask

  initial begin
    t_reset();
    t_mode_prev();
    t_mode_now();
    t_ignore();
    t_invert();
    t_disabled(1'b0);
    t_disabled(1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule